// File: doc/BRIEF.md
# Read-Return Serial Receiver with CRC Check

This block sits on the host side of a serial display link. It recovers the data word that the display side sends back during a CPU read. The return line is single-ended and idles high. The block samples it with an internal clock that runs at four times the return bit rate, because read data travels at one quarter of the forward rate. A falling edge on the line marks the start of a return frame. From that edge the receiver fixes one sampling phase in the middle of the start bit and keeps it for the whole frame. This absorbs the unknown round-trip delay of the cable.

A frame holds three parts: a start bit, then an 18-bit data word sent most significant bit first, then a 5-bit check code sent most significant bit first. The receiver builds the check code from the data bits as they arrive and compares it with the received code. It then shows the word on a parallel output with a one-cycle valid strobe. If the codes differ, it raises a sticky error flag. A write-only configuration input turns off read reception completely. Hosts with a narrower bus tie the unused upper data bits to a fixed level on the far side, and the block treats them as ordinary data.

Top module: `rr_read_rx`

## Requirements
- R1: After reset, and while the line stays high, rd_valid, rd_data and rd_err are all 0.
- R2: A frame starts when the line, after a SYNC_STAGES-flop synchronizer (default 2), goes from 1 to 0 while the receiver is idle. This accepted edge clears rd_err. rd_err reads 0 after the rising edge that comes SYNC_STAGES cycles after the first edge at which the start bit is present on rx_line.
- R3: The line is sampled once per bit. The first sample is taken SAMPLE_OFS (default 2) clocks into the start bit, and each later sample comes exactly OVS (default 4) clocks after the one before. Values on the other ticks of a bit have no effect on the received word.
- R4: If the start-bit sample reads 1, the edge is treated as a glitch. The receiver returns to idle, no rd_valid pulse is produced and rd_data is unchanged. rd_err is still cleared as stated in R2.
- R5: The frame is one start bit (0), then 18 data bits MSB first, then 5 check bits MSB first, and the line then returns high. On the valid pulse rd_data carries the 18 data bits, with the first bit received at bit 17. rd_data holds its value between pulses.
- R6: The check code uses the polynomial x^5 + x^2 + 1, taps 5'b00101, in a shift register preset to 5'b11111. It covers the 18 data bits only and is shifted MSB first. On the valid pulse, rd_err becomes 1 if the received code differs and 0 if it matches. rd_err then holds until the next accepted start edge.
- R7: rd_valid is high for exactly one cycle. This cycle follows the rising edge that is 96 clocks after the first edge at which the start bit is present on rx_line (default parameters).
- R8: While wr_only is 1 at a rising edge, no start edge is accepted and an open frame is dropped. This holds even on the edge that would take the final check bit. A dropped frame gives no rd_valid pulse and leaves rd_data unchanged. It also leaves rd_err unchanged, except for a clear already made by R2.
- R9: A new frame that starts after only one idle bit time (OVS clocks high) is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVS ticks per return bit |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Single-ended serial read-return line, idles high |
| wr_only | input | 1 | 1 disables read reception and drops an open frame |
| rd_data | output | 18 | Last received data word |
| rd_valid | output | 1 | One-cycle strobe, a new word is on rd_data |
| rd_err | output | 1 | Check-code mismatch on the last completed frame |

## Verification
Two things can land on the same rising edge. One is the capture of the final check bit, which would complete the frame. The other is wr_only going high, which drops the frame. To provoke this, the bench raises wr_only for exactly one edge, the one that should take the last check bit. It then repeats the run with the pulse one edge later. The first run must show no valid pulse, with rd_data and rd_err unchanged. The second must show a normal completion. A cycle-accurate reference model in the bench compares all three outputs on every clock. It runs this pair alongside an abort in the middle of a frame and a write-only setting held across a whole frame.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_CRC   = 2'd3
  } rr_state_e;
endpackage

// File: rtl/rr_sync.sv
module rr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '1;
      q_prev <= 1'b1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      q_prev <= chain[STAGES-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rr_crc.sv
module rr_crc #(
  parameter int             W    = 5,
  parameter logic [W-1:0]   POLY = 5'b00101,
  parameter logic [W-1:0]   INIT = 5'b11111
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic         fb;
  logic [W-1:0] nxt;

  assign fb = crc_o[W-1] ^ bit_i;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[i] = POLY[i] & fb;
    end else begin : g_upper
      assign nxt[i] = crc_o[i-1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) crc_o <= INIT;
    else if (en)     crc_o <= nxt;
  end
endmodule

// File: rtl/rr_ctrl.sv
module rr_ctrl
  import rr_pkg::*;
#(
  parameter int OVS        = 4,
  parameter int SAMPLE_OFS = 2,
  parameter int DATA_W     = 18,
  parameter int CRC_W      = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic line_prev,
  input  logic wr_only,
  output logic frame_go,
  output logic take_data,
  output logic take_crc,
  output logic take_last
);
  localparam int TICK_W = $clog2(OVS + 1);
  localparam int MAXB   = (DATA_W > CRC_W) ? DATA_W : CRC_W;
  localparam int CNT_W  = $clog2(MAXB + 1);
  localparam logic [TICK_W-1:0] TICK_END  = TICK_W'(OVS);
  localparam logic [TICK_W-1:0] TICK_MID  = TICK_W'(SAMPLE_OFS);
  localparam logic [TICK_W-1:0] TICK_ONE  = TICK_W'(1);
  localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0]  CRC_LAST  = CNT_W'(CRC_W - 1);

  rr_state_e         state;
  logic [TICK_W-1:0] tick;
  logic [CNT_W-1:0]  bitcnt;
  logic              fall, at_end;

  assign fall      = line_prev & ~line;
  assign at_end    = (tick == TICK_END);
  assign frame_go  = (state == ST_IDLE) && fall && !wr_only;
  assign take_data = !wr_only && (state == ST_DATA) && at_end;
  assign take_crc  = !wr_only && (state == ST_CRC) && at_end;
  assign take_last = take_crc && (bitcnt == CRC_LAST);

  always_ff @(posedge clk) begin
    if (rst || wr_only) begin
      state  <= ST_IDLE;
      tick   <= '0;
      bitcnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fall) begin
            state <= ST_START;
            tick  <= TICK_ONE;
          end
        end
        ST_START: begin
          if (tick == TICK_MID) begin
            tick   <= TICK_ONE;
            bitcnt <= '0;
            state  <= line ? ST_IDLE : ST_DATA;
          end else begin
            tick <= tick + TICK_ONE;
          end
        end
        ST_DATA: begin
          if (at_end) begin
            tick <= TICK_ONE;
            if (bitcnt == DATA_LAST) begin
              state  <= ST_CRC;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end else begin
            tick <= tick + TICK_ONE;
          end
        end
        default: begin
          if (at_end) begin
            tick <= TICK_ONE;
            if (bitcnt == CRC_LAST) begin
              state  <= ST_IDLE;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end else begin
            tick <= tick + TICK_ONE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rr_read_rx.sv
module rr_read_rx #(
  parameter int                DATA_W      = 18,
  parameter int                CRC_W       = 5,
  parameter logic [CRC_W-1:0]  CRC_POLY    = 5'b00101,
  parameter logic [CRC_W-1:0]  CRC_INIT    = 5'b11111,
  parameter int                OVS         = 4,
  parameter int                SAMPLE_OFS  = 2,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              wr_only,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_err
);
  logic              line_s, line_q;
  logic              frame_go, take_data, take_crc, take_last;
  logic [CRC_W-1:0]  crc_acc;
  logic [DATA_W-1:0] data_sh;
  logic [CRC_W-1:0]  crc_sh;
  logic              mismatch;

  rr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rx_line), .q(line_s), .q_prev(line_q)
  );

  rr_ctrl #(
    .OVS(OVS), .SAMPLE_OFS(SAMPLE_OFS), .DATA_W(DATA_W), .CRC_W(CRC_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .line(line_s), .line_prev(line_q),
    .wr_only(wr_only), .frame_go(frame_go), .take_data(take_data),
    .take_crc(take_crc), .take_last(take_last)
  );

  rr_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst(rst), .init(frame_go), .en(take_data),
    .bit_i(line_s), .crc_o(crc_acc)
  );

  assign mismatch = ({crc_sh[CRC_W-2:0], line_s} != crc_acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_sh <= '0;
      crc_sh  <= '0;
    end else begin
      if (take_data) data_sh <= {data_sh[DATA_W-2:0], line_s};
      if (take_crc)  crc_sh  <= {crc_sh[CRC_W-2:0], line_s};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= take_last;
      if (take_last) begin
        rd_data <= data_sh;
        rd_err  <= mismatch;
      end else if (frame_go) begin
        rd_err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rr_read_rx_chk.sv
module rr_read_rx_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_only,
  input logic              frame_go,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_err
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);  // R7
  AST_WO_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_only |=> !rd_valid);  // R8
  AST_ERR_RISE_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_err) |-> rd_valid);  // R6
  AST_ERR_FALL_ON_START: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_err) |-> ($past(frame_go) || rd_valid));  // R2
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));  // R5
endmodule

bind rr_read_rx rr_read_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_only(wr_only), .frame_go(frame_go),
  .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err)
);

// File: tb/sim_rr_read_rx.sv
`timescale 1ns/1ps
module sim_rr_read_rx;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_line = 1'b1;
  logic          wr_only = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          rd_err;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  bit            pend = 0, pcancel = 0, pglitch = 0, perr = 0;
  int            pS = 1000000;
  logic [DW-1:0] pdata = '0;
  logic [DW-1:0] exp_data = '0;
  bit            exp_valid = 0, exp_err = 0;
  // scheduled write-only window, relative to frame start
  bit wo_arm = 0;
  int wo_from = 0, wo_to = 0;

  rr_read_rx u0 (
    .clk(clk), .rst(rst), .rx_line(rx_line), .wr_only(wr_only),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err)
  );

  always #5 clk = ~clk;

  function automatic logic [4:0] ref_crc(input logic [DW-1:0] d);
    int c = 31;
    for (int i = DW - 1; i >= 0; i--) begin
      int top = (c >> 4) & 1;
      c = (c << 1) & 31;
      if ((top ^ int'(d[i])) != 0) c = c ^ 5;
    end
    return 5'(c);
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", cur_req, what, cyc, act, exp);
    end
  endtask

  // model: advances on each rising edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    exp_valid = 0;
    if (pend) begin
      if (wr_only && cyc >= pS + 2 && cyc <= pS + 96) pcancel = 1;
      if (cyc == pS + 2) begin
        if (!pcancel) exp_err = 0;
        if (pglitch || pcancel) pend = 0;
      end
      if (pend && cyc == pS + 96) begin
        if (!pcancel) begin
          exp_valid = 1;
          exp_data  = pdata;
          exp_err   = perr;
        end
        pend = 0;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(rd_valid === exp_valid, "rd_valid (R7/R8)", int'(rd_valid), int'(exp_valid));
      check(rd_data === exp_data, "rd_data (R5)", int'(rd_data), int'(exp_data));
      check(rd_err === exp_err, "rd_err (R6/R2)", int'(rd_err), int'(exp_err));
    end
    if (wo_arm) wr_only <= (cyc + 1 >= pS + wo_from) && (cyc + 1 <= pS + wo_to);
  end

  task automatic send_frame(input logic [DW-1:0] d, input logic [4:0] cx,
                            input bit noisy, input bit glitch, input int gap);
    logic [22:0] bits;
    bits = {d, ref_crc(d) ^ cx};
    @(negedge clk);
    pS = cyc + 1; pdata = d; perr = (cx != 0); pglitch = glitch; pcancel = 0; pend = 1;
    rx_line = 1'b0;
    @(negedge clk) rx_line = 1'b0;
    if (glitch) begin
      @(negedge clk) rx_line = 1'b1;
    end else begin
      @(negedge clk) rx_line = 1'b0;
      @(negedge clk) rx_line = noisy;
      for (int i = 22; i >= 0; i--) begin
        for (int t = 0; t < 4; t++) begin
          @(negedge clk) rx_line = (noisy && t != 2) ? ~bits[i] : bits[i];
        end
      end
    end
    for (int g = 0; g < gap; g++) @(negedge clk) rx_line = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(rd_valid === 1'b0 && rd_err === 1'b0 && rd_data === '0, "reset outputs R1",
          int'({rd_valid, rd_err}), 0);
    @(negedge clk) rst = 1'b0;
    repeat (20) @(negedge clk);               // R1 idle line, model compares zeros

    cur_req = "R5";
    send_frame(18'h2B3C5, 5'h00, 0, 0, 8);
    send_frame(18'h3FFFF, 5'h00, 0, 0, 8);
    send_frame(18'h00000, 5'h00, 0, 0, 8);
    send_frame(18'h15555, 5'h00, 0, 0, 8);

    cur_req = "R6";
    send_frame(18'h1A2B3, 5'h01, 0, 0, 8);     // corrupted code sets rd_err
    send_frame(18'h0C0DE, 5'h10, 0, 0, 8);
    cur_req = "R2";
    send_frame(18'h12345, 5'h00, 0, 0, 8);     // clears at S+2, stays clear

    cur_req = "R3";
    send_frame(18'h0F0F3, 5'h00, 1, 0, 8);     // garbage on ticks 0,1,3
    send_frame(18'h2AAAA, 5'h00, 1, 0, 8);

    cur_req = "R4";
    send_frame(18'h00111, 5'h04, 0, 0, 8);     // error set first
    send_frame(18'h3C3C3, 5'h00, 0, 1, 8);     // glitch: clears err, no valid
    send_frame(18'h05A5A, 5'h00, 0, 0, 8);

    cur_req = "R9";
    send_frame(18'h11111, 5'h00, 0, 0, 4);
    send_frame(18'h22222, 5'h02, 0, 0, 4);
    send_frame(18'h33333, 5'h00, 0, 0, 8);

    cur_req = "R8";
    send_frame(18'h0ABCD, 5'h08, 0, 0, 8);     // leave rd_err set
    @(negedge clk) wr_only = 1'b1;
    send_frame(18'h3EEEE, 5'h00, 0, 0, 8);     // whole frame blocked
    @(negedge clk) wr_only = 1'b0;
    repeat (8) @(negedge clk);
    wo_from = 40; wo_to = 100; wo_arm = 1;     // abort mid-frame
    send_frame(18'h2DDDD, 5'h00, 0, 0, 12);
    wo_from = 96; wo_to = 96;                  // same edge as last check bit
    send_frame(18'h1BBBB, 5'h00, 0, 0, 12);
    cur_req = "R7";
    wo_from = 97; wo_to = 97;                  // one edge later: completes
    send_frame(18'h09999, 5'h00, 0, 0, 12);
    wo_arm = 0;
    @(negedge clk) wr_only = 1'b0;
    repeat (10) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule